// File: doc/BRIEF.md
# Display Power Domain Sequencer

This block brings a video/display power domain up and down in hardware. It owns the domain power-switch control, the isolation control, the domain reset, and the enables for the main clock and the bus clock. It also owns a bank of memory power-down bits, which it changes a few bits at a time. The bank has two or three 32-bit groups and one 8-bit group. Every stage of the sequence is followed by a wait of a fixed length. All waits are counted in clock cycles, derived from a clock-frequency parameter given in MHz.

Software asks for a transition by pulsing a power-up or power-down request while the block is idle. When the last output of the sequence changes, the block returns a one-cycle acknowledge. The power-switch control doubles as the status bit, because it reads 1 whenever the domain is off. The two directions are deliberately asymmetric:

- Power-down isolates the domain first and cuts its clocks last.
- Power-up switches the domain on first. It then releases isolation while the reset is held, and only after that enables the clocks.

Top module: `pds_seq_ctrl`

## Requirements
- R1: After reset the switch control is 1 (off), isolation and domain reset are 1, both clock enables are 0, every memory power-down bit is 1, and the acknowledge is 0.
- R2: On a power-down request with the domain on, isolation rises in the cycle after the request is sampled. The first memory step follows 20 us later.
- R3: Memory steps go in this order: wide group 0, wide group 1, then (if present) wide group 2, then the 8-bit group. Each wide group changes bits 1:0 first and then each higher pair, one pair per step. The 8-bit group changes one bit per step, from bit 0 upward. Consecutive steps are exactly 5 us apart. Power-down writes 1 and power-up writes 0.
- R4: Parameter USE_THIRD_GROUP=1 adds a third wide group, with 16 more steps before the 8-bit group. With USE_THIRD_GROUP=0 there are two wide groups.
- R5: After the last memory step there is a 5 us step wait and then a 20 us wait. On power-down the switch control then goes to 1, while isolation is still 1.
- R6: On power-down, the main clock enable falls 20 ms after the switch goes off. The bus clock enable falls one cycle later.
- R7: On power-up, the switch control goes to 0 in the cycle after the request is sampled. The memory bits are cleared starting 20 us later.
- R8: On power-up, the domain reset is asserted 25 us after the last memory step. Then, one cycle apart each: isolation falls, reset falls, the main clock enable rises, and the bus clock enable rises.
- R9: A power-down request made while the switch control reads 1 changes no output and produces no acknowledge.
- R10: Requests that arrive while a sequence is running are ignored.
- R11: The acknowledge is high for exactly one cycle, in the same cycle as the final clock-enable change of a sequence.
- R12: A wait of D us lasts CLK_MHZ*D cycles, and a wait of D ms lasts CLK_MHZ*D*1000 cycles.
- R13: If both requests are sampled together while idle with the domain on, power-down runs. With the domain off, power-up runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_req | input | 1 | Request to power the domain up |
| pwr_down_req | input | 1 | Request to power the domain down |
| pwr_ack | output | 1 | One-cycle pulse when a sequence completes |
| pwr_sw_off | output | 1 | Domain switch control and status, 1 = off |
| iso_en | output | 1 | Domain isolation, 1 = isolated |
| dom_rst | output | 1 | Domain reset, 1 = held |
| clk_main_en | output | 1 | Main clock enable |
| clk_bus_en | output | 1 | Bus clock enable |
| mem_pd_wide | output | WORD_W*(2+USE_THIRD_GROUP) | Wide memory power-down groups, group g at bits 32g+31:32g |
| mem_pd_narrow | output | NARROW_W | Narrow memory power-down group |

## Verification
The assertions assume that reset is held from time zero until the first clock edge. Under that assumption every history term starts from the reset state. They also assume that requests are single-cycle levels sampled on the clock, with no further condition on when they arrive.

The bench obeys both assumptions. It keeps reset high for several cycles at start-up, and it drives each request for exactly one cycle at a falling edge. It also fires stray and simultaneous requests in the middle of running sequences. This keeps the ordering properties under stress without leaving the inputs they rely on.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DN_MEM,
    ST_DN_TAIL,
    ST_DN_SWITCH,
    ST_DN_CLKM,
    ST_DN_CLKB,
    ST_UP_MEM,
    ST_UP_TAIL,
    ST_UP_RST,
    ST_UP_ISO,
    ST_UP_RREL,
    ST_UP_CLKM,
    ST_UP_CLKB
  } seq_state_t;
endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R12: a freshly loaded count is the value given, never skipped
  assert_load_taken_R12: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/pds_mem_stepper.sv
module pds_mem_stepper #(
  parameter int WIDE_GROUPS = 2,
  parameter int WORD_W      = 32,
  parameter int PAIR_W      = 2,
  parameter int NARROW_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          step,
  input  logic                          level,
  output logic                          last,
  output logic [WIDE_GROUPS*WORD_W-1:0] wide_q,
  output logic [NARROW_W-1:0]           narrow_q
);
  localparam int SPW   = WORD_W / PAIR_W;
  localparam int WIDE_STEPS = WIDE_GROUPS * SPW;
  localparam int TOTAL = WIDE_STEPS + NARROW_W;
  localparam int IDX_W = $clog2(TOTAL + 1);

  logic [IDX_W-1:0]              idx_q;
  logic [WIDE_GROUPS*WORD_W-1:0] wide_d;
  logic [NARROW_W-1:0]           narrow_d;

  assign last = (idx_q == IDX_W'(TOTAL - 1));

  always_comb begin
    wide_d   = wide_q;
    narrow_d = narrow_q;
    for (int g = 0; g < WIDE_GROUPS; g++) begin
      for (int p = 0; p < SPW; p++) begin
        if (step && (int'(idx_q) == g * SPW + p)) begin
          wide_d[g*WORD_W + p*PAIR_W +: PAIR_W] = {PAIR_W{level}};
        end
      end
    end
    for (int b = 0; b < NARROW_W; b++) begin
      if (step && (int'(idx_q) == WIDE_STEPS + b)) begin
        narrow_d[b] = level;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      wide_q   <= '1;
      narrow_q <= '1;
    end else begin
      wide_q   <= wide_d;
      narrow_q <= narrow_d;
      if (start) begin
        idx_q <= '0;
      end else if (step) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R3: never more than one pair of bits moves in a single cycle
  assert_step_width_R3: assert property (@(posedge clk) disable iff (rst)
    (($countones(wide_q ^ $past(wide_q)) +
      $countones(narrow_q ^ $past(narrow_q))) <= PAIR_W));
endmodule

// File: rtl/pds_seq_ctrl.sv
module pds_seq_ctrl #(
  parameter int CLK_MHZ         = 50,
  parameter bit USE_THIRD_GROUP = 1'b0,
  parameter int PRE_WAIT_US     = 20,
  parameter int STEP_WAIT_US    = 5,
  parameter int POST_WAIT_US    = 20,
  parameter int SETTLE_MS       = 20,
  parameter int WORD_W          = 32,
  parameter int PAIR_W          = 2,
  parameter int NARROW_W        = 8
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        pwr_up_req,
  input  logic                                        pwr_down_req,
  output logic                                        pwr_ack,
  output logic                                        pwr_sw_off,
  output logic                                        iso_en,
  output logic                                        dom_rst,
  output logic                                        clk_main_en,
  output logic                                        clk_bus_en,
  output logic [(2+int'(USE_THIRD_GROUP))*WORD_W-1:0] mem_pd_wide,
  output logic [NARROW_W-1:0]                         mem_pd_narrow
);
  import pds_pkg::*;

  localparam int WIDE_GROUPS = 2 + int'(USE_THIRD_GROUP);
  localparam int PRE_CYC     = CLK_MHZ * PRE_WAIT_US;
  localparam int STEP_CYC    = CLK_MHZ * STEP_WAIT_US;
  localparam int POST_CYC    = CLK_MHZ * POST_WAIT_US;
  localparam int SETTLE_CYC  = CLK_MHZ * SETTLE_MS * 1000;
  localparam int MAX_A       = (PRE_CYC > STEP_CYC) ? PRE_CYC : STEP_CYC;
  localparam int MAX_B       = (POST_CYC > SETTLE_CYC) ? POST_CYC : SETTLE_CYC;
  localparam int MAX_CYC     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  seq_state_t       state_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             stp_start;
  logic             stp_step;
  logic             stp_last;
  logic             dn_go;

  assign dn_go = pwr_down_req && !pwr_sw_off;

  pds_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  pds_mem_stepper #(
    .WIDE_GROUPS (WIDE_GROUPS),
    .WORD_W      (WORD_W),
    .PAIR_W      (PAIR_W),
    .NARROW_W    (NARROW_W)
  ) u_stepper (
    .clk      (clk),
    .rst      (rst),
    .start    (stp_start),
    .step     (stp_step),
    .level    (state_q == ST_DN_MEM),
    .last     (stp_last),
    .wide_q   (mem_pd_wide),
    .narrow_q (mem_pd_narrow)
  );

  always_comb begin
    tmr_load  = 1'b0;
    tmr_val   = '0;
    stp_start = 1'b0;
    stp_step  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dn_go || pwr_up_req) begin
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(PRE_CYC - 1);
          stp_start = 1'b1;
        end
      end
      ST_DN_MEM, ST_UP_MEM: begin
        if (tmr_done) begin
          stp_step = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(STEP_CYC - 1);
        end
      end
      ST_DN_TAIL, ST_UP_TAIL: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(POST_CYC - 1);
        end
      end
      ST_DN_SWITCH: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETTLE_CYC - 1);
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pwr_ack     <= 1'b0;
      pwr_sw_off  <= 1'b1;
      iso_en      <= 1'b1;
      dom_rst     <= 1'b1;
      clk_main_en <= 1'b0;
      clk_bus_en  <= 1'b0;
    end else begin
      pwr_ack <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (dn_go) begin
            iso_en  <= 1'b1;
            state_q <= ST_DN_MEM;
          end else if (pwr_up_req) begin
            pwr_sw_off <= 1'b0;
            state_q    <= ST_UP_MEM;
          end
        end
        ST_DN_MEM:    if (tmr_done && stp_last) state_q <= ST_DN_TAIL;
        ST_DN_TAIL:   if (tmr_done) state_q <= ST_DN_SWITCH;
        ST_DN_SWITCH: begin
          if (tmr_done) begin
            pwr_sw_off <= 1'b1;
            state_q    <= ST_DN_CLKM;
          end
        end
        ST_DN_CLKM: begin
          if (tmr_done) begin
            clk_main_en <= 1'b0;
            state_q     <= ST_DN_CLKB;
          end
        end
        ST_DN_CLKB: begin
          clk_bus_en <= 1'b0;
          pwr_ack    <= 1'b1;
          state_q    <= ST_IDLE;
        end
        ST_UP_MEM:  if (tmr_done && stp_last) state_q <= ST_UP_TAIL;
        ST_UP_TAIL: if (tmr_done) state_q <= ST_UP_RST;
        ST_UP_RST: begin
          if (tmr_done) begin
            dom_rst <= 1'b1;
            state_q <= ST_UP_ISO;
          end
        end
        ST_UP_ISO: begin
          iso_en  <= 1'b0;
          state_q <= ST_UP_RREL;
        end
        ST_UP_RREL: begin
          dom_rst <= 1'b0;
          state_q <= ST_UP_CLKM;
        end
        ST_UP_CLKM: begin
          clk_main_en <= 1'b1;
          state_q     <= ST_UP_CLKB;
        end
        ST_UP_CLKB: begin
          clk_bus_en <= 1'b1;
          pwr_ack    <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: the switch is only opened on an isolated domain
  assert_iso_before_off_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_sw_off) |-> iso_en);

  // R8: isolation is dropped only while the domain reset is held
  assert_iso_release_in_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> dom_rst);

  // R8: main clock comes up only on a released, de-isolated domain
  assert_clk_after_release_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_main_en) |-> (!iso_en && !dom_rst));

  // R6: bus clock drops only after the main clock is already off
  assert_bus_after_main_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_bus_en) |-> !clk_main_en);

  // R11: acknowledge is a single-cycle pulse
  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    pwr_ack |=> !pwr_ack);

  // R3: memory bits move only while the domain switch is on
  assert_mem_while_on_R3: assert property (@(posedge clk) disable iff (rst)
    ((mem_pd_wide != $past(mem_pd_wide)) || (mem_pd_narrow != $past(mem_pd_narrow)))
      |-> !pwr_sw_off);
endmodule

// File: tb/pds_seq_ctrl_test.sv
module pds_seq_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks   = 0;
  int failures = 0;

  // instance A: 2 MHz, three wide groups; instance B: 1 MHz, two wide groups
  logic        up_a = 1'b0, dn_a = 1'b0, up_b = 1'b0, dn_b = 1'b0;
  logic        ack_a, sw_a, iso_a, rst_a, cm_a, cb_a;
  logic        ack_b, sw_b, iso_b, rst_b, cm_b, cb_b;
  logic [95:0] wide_a;
  logic [63:0] wide_b;
  logic [7:0]  nar_a, nar_b;

  pds_seq_ctrl #(.CLK_MHZ(2), .USE_THIRD_GROUP(1'b1), .SETTLE_MS(1)) uut (
    .clk(clk), .rst(rst), .pwr_up_req(up_a), .pwr_down_req(dn_a),
    .pwr_ack(ack_a), .pwr_sw_off(sw_a), .iso_en(iso_a), .dom_rst(rst_a),
    .clk_main_en(cm_a), .clk_bus_en(cb_a),
    .mem_pd_wide(wide_a), .mem_pd_narrow(nar_a));

  pds_seq_ctrl #(.CLK_MHZ(1), .USE_THIRD_GROUP(1'b0), .SETTLE_MS(1)) uut_b (
    .clk(clk), .rst(rst), .pwr_up_req(up_b), .pwr_down_req(dn_b),
    .pwr_ack(ack_b), .pwr_sw_off(sw_b), .iso_en(iso_b), .dom_rst(rst_b),
    .clk_main_en(cm_b), .clk_bus_en(cb_b),
    .mem_pd_wide(wide_b), .mem_pd_narrow(nar_b));

  function automatic logic [95:0] lowmask(int n);
    logic [95:0] m = '0;
    for (int i = 0; i < 96; i++) m[i] = (i < n);
    return m;
  endfunction

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_req(int inst, bit up, bit dn);
    if (inst == 0) begin up_a = up; dn_a = dn; end
    else begin up_b = up; dn_b = dn; end
  endtask

  task automatic grab(int inst, output logic [95:0] w, output logic [7:0] n,
                      output logic [5:0] c);
    if (inst == 0) begin
      w = wide_a; n = nar_a; c = {ack_a, sw_a, iso_a, rst_a, cm_a, cb_a};
    end else begin
      w = {32'b0, wide_b}; n = nar_b; c = {ack_b, sw_b, iso_b, rst_b, cm_b, cb_b};
    end
  endtask

  // Runs one full sequence, comparing every output every cycle against
  // values computed from the requirements.
  task automatic run_seq(int inst, bit down, bit both, bit rst_init);
    int U   = (inst == 0) ? 2 : 1;
    int G   = (inst == 0) ? 3 : 2;
    int N   = 16 * G + 8;
    int T   = 20 * U + 5 * U * N + 20 * U;
    int SET = 1000 * U;
    int L   = down ? (T + SET + 1) : (T + 4);
    int acks = 0;
    string mtag = (inst == 0) ? "R3/R4/R12" : "R3";
    logic [95:0] w;
    logic [7:0]  nb;
    logic [5:0]  c;
    @(negedge clk);
    set_req(inst, both | !down, both | down);
    for (int k = 0; k <= L + 4; k++) begin
      int n;
      logic [95:0] wm, gm, ew;
      logic [7:0]  nm, en;
      bit e_sw, e_iso, e_rst, e_cm, e_cb, e_ack;
      @(negedge clk);
      set_req(inst, 1'b0, 1'b0);
      grab(inst, w, nb, c);
      n = (k < 20 * U) ? 0 : ((k - 20 * U) / (5 * U) + 1);
      if (n > N) n = N;
      wm = lowmask(2 * ((n < 16 * G) ? n : 16 * G));
      gm = lowmask(32 * G);
      nm = lowmask((n > 16 * G) ? (n - 16 * G) : 0);
      if (down) begin
        ew = wm & gm; en = nm;
        e_sw = (k >= T); e_iso = 1'b1; e_rst = rst_init;
        e_cm = (k < T + SET); e_cb = (k < T + SET + 1); e_ack = (k == T + SET + 1);
      end else begin
        ew = ~wm & gm; en = ~nm;
        e_sw = 1'b0; e_iso = (k < T + 1);
        e_rst = (k < T) ? rst_init : (k < T + 2);
        e_cm = (k >= T + 3); e_cb = (k >= T + 4); e_ack = (k == T + 4);
      end
      chk(mtag, w, ew);
      chk(mtag, {88'b0, nb}, {88'b0, en});
      chk(down ? "R5" : "R7", {95'b0, c[4]}, {95'b0, e_sw});
      chk(down ? "R2" : "R8", {95'b0, c[3]}, {95'b0, e_iso});
      chk("R8", {95'b0, c[2]}, {95'b0, e_rst});
      chk(down ? "R6" : "R8", {95'b0, c[1]}, {95'b0, e_cm});
      chk(down ? "R6" : "R8", {95'b0, c[0]}, {95'b0, e_cb});
      chk("R11", {95'b0, c[5]}, {95'b0, e_ack});
      if (c[5]) acks++;
      // R10: both requests pulsed mid-sequence must be ignored
      if (k == 30) set_req(inst, 1'b1, 1'b1);
    end
    chk("R10/R11 ack count", 96'(acks), 96'd1);
  endtask

  initial begin
    logic [95:0] w;
    logic [7:0]  nb;
    logic [5:0]  c;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of both instances
    for (int i = 0; i < 2; i++) begin
      grab(i, w, nb, c);
      chk("R1 wide", w, lowmask(i == 0 ? 96 : 64));
      chk("R1 narrow", {88'b0, nb}, {88'b0, 8'hff});
      chk("R1 controls", {90'b0, c}, {90'b0, 6'b011100});
    end
    // R9: power-down request while already off
    @(negedge clk);
    dn_a = 1'b1;
    @(negedge clk);
    dn_a = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      grab(0, w, nb, c);
      chk("R9 controls", {90'b0, c}, {90'b0, 6'b011100});
      chk("R9 wide", w, lowmask(96));
    end
    run_seq(0, 1'b0, 1'b0, 1'b1);
    run_seq(0, 1'b1, 1'b0, 1'b0);
    run_seq(0, 1'b0, 1'b0, 1'b0);
    run_seq(1, 1'b0, 1'b0, 1'b1);
    // R13: both requests while on selects power-down
    run_seq(1, 1'b1, 1'b1, 1'b0);
    chk("R13 off after both", {95'b0, sw_b}, 96'd1);
    // R13: both requests while off selects power-up
    run_seq(1, 1'b0, 1'b1, 1'b0);
    chk("R13 on after both", {95'b0, sw_b}, 96'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R11: sequence never completed");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule